// File: doc/BRIEF.md
# Framed HDLC Receiver

This block recovers HDLC frames from a channelised T1/E1 bit stream. On every strobe the framer presents one serial bit together with its time-slot number and its bit position within the slot. A slot mask and a lane mask pick which positions carry the data link. The slots may be any set, contiguous or not, and the lanes may be any subset of the eight bits of a slot. Only the picked bits enter the receiver. Every other bit is discarded before it reaches the receiver.

The receiver first hunts for a flag. It then byte-aligns the data to the first bit after the flag, removes stuffed zeros, and runs a CRC-16 over every completed byte. Payload bytes go into a 128-entry show-ahead FIFO. Each entry holds a data byte and a two-bit tag. The last payload byte of a message carries an end-of-message tag that gives the outcome. The two check bytes are held back and never reach the FIFO. The host pops entries one at a time with a read strobe.

Top module: `hdlc_frame_rx`

## Requirements
- R1: A bit is consumed only when `bit_valid` is high, `slot_mask[slot_idx]` is set and `bit_mask[bit_idx]` is set. Any other input has no effect on the FIFO contents.
- R2: The pattern 0,1,1,1,1,1,1,0 in consumed bits is a flag. It opens and closes messages. Bytes are assembled from the first consumed bit after a flag, least significant bit first.
- R3: A zero that follows five consecutive ones in the consumed bits is removed from the data.
- R4: At a closing flag, a message of at least four bytes (check bytes included) that ends byte-aligned, and whose CRC-16 residue is 0xF0B8, stores its last payload byte with tag 1 (good). Earlier payload bytes carry tag 0 (data). The two check bytes are not stored. The CRC uses the reflected polynomial 0x8408 with a seed of 0xFFFF.
- R5: At a closing flag, a message of at least four bytes that fails the residue test, or that ends with a partial byte, stores its last held payload byte with tag 2 (bad).
- R6: A message of fewer than four bytes between flags leaves no entry in the FIFO.
- R7: Seven consecutive ones abort the current message. If at least one byte had been received, the oldest byte still held is stored with tag 3 (abort). The receiver then ignores data until the next flag, and the next message is received normally.
- R8: The FIFO holds 128 entries. `rd_data` and `rd_tag` show the oldest entry while `rx_empty` is low, and `rd_en` removes that entry.
- R9: A store attempted while the FIFO is full sets `rx_overrun`, which stays set until reset. The rest of that message, including its end tag, is dropped. The next message after a flag is stored normally.
- R10: After reset the FIFO is empty, `rx_overrun` is low and the receiver hunts for a flag, so bits that precede the first flag store nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_valid | input | 1 | A stream bit is presented this cycle |
| slot_idx | input | 5 | Time slot of the presented bit |
| bit_idx | input | 3 | Bit position within the slot |
| rx_bit | input | 1 | Serial data bit |
| slot_mask | input | 32 | One enable per time slot |
| bit_mask | input | 8 | One enable per bit position within a slot |
| rd_en | input | 1 | Pop the oldest FIFO entry |
| rd_data | output | 8 | Oldest entry's data byte |
| rd_tag | output | 2 | Oldest entry's tag: 0 data, 1 good end, 2 bad end, 3 abort |
| rx_empty | output | 1 | FIFO holds no entries |
| rx_overrun | output | 1 | Sticky FIFO overrun indication |

## Verification
Each consumed bit is taken on the rising edge at which it is presented. A byte completion, a closing flag or an abort writes its FIFO entry on that same edge, so the entry can be seen on the outputs immediately after it. A pop takes effect on the edge at which `rd_en` is high. The bench drives all inputs on falling edges and reads `rd_data`, `rd_tag`, `rx_empty` and `rx_overrun` on a later falling edge. Every result is therefore read half a cycle or more after the edge that produced it, and never at an edge.

// File: rtl/hdlc_rx_pkg.sv
package hdlc_rx_pkg;

  typedef enum logic [1:0] {
    TAG_DATA  = 2'd0,
    TAG_GOOD  = 2'd1,
    TAG_BAD   = 2'd2,
    TAG_ABORT = 2'd3
  } rx_tag_e;

  typedef struct packed {
    rx_tag_e    tag;
    logic [7:0] data;
  } rx_entry_t;

  localparam logic [15:0] CRC_SEED         = 16'hFFFF;
  localparam logic [15:0] CRC_POLY_REFL    = 16'h8408;
  localparam logic [15:0] CRC_GOOD_RESIDUE = 16'hF0B8;

  // Advance a reflected CRC-16 by one octet, least significant bit first.
  function automatic logic [15:0] crc16_octet(input logic [15:0] crc_in,
                                              input logic [7:0]  octet);
    logic [15:0] c;
    c = crc_in;
    for (int i = 0; i < 8; i++) begin
      if (c[0] ^ octet[i]) c = (c >> 1) ^ CRC_POLY_REFL;
      else                 c = c >> 1;
    end
    return c;
  endfunction

endpackage

// File: rtl/hdlc_rx_map.sv
module hdlc_rx_map #(
  parameter int  SLOTS = 32,
  parameter int  LANES = 8,
  localparam int SW    = $clog2(SLOTS),
  localparam int BW    = $clog2(LANES)
) (
  input  logic             bit_valid,
  input  logic [SW-1:0]    slot_idx,
  input  logic [BW-1:0]    bit_idx,
  input  logic [SLOTS-1:0] slot_mask,
  input  logic [LANES-1:0] bit_mask,
  output logic             bit_en
);

  logic [SLOTS-1:0] slot_hit;
  logic [LANES-1:0] lane_hit;

  generate
    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
      assign slot_hit[s] = slot_mask[s] && (slot_idx == SW'(s));
    end
    for (genvar l = 0; l < LANES; l++) begin : g_lane
      assign lane_hit[l] = bit_mask[l] && (bit_idx == BW'(l));
    end
  endgenerate

  assign bit_en = bit_valid && (|slot_hit) && (|lane_hit);

endmodule

// File: rtl/hdlc_rx_deframe.sv
module hdlc_rx_deframe
  import hdlc_rx_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      bit_en,
  input  logic      rx_bit,
  output logic      push,
  output rx_entry_t push_entry,
  output logic      frame_open
);

  localparam logic [2:0] RUN_STUFF = 3'd5;
  localparam logic [2:0] RUN_FLAG  = 3'd6;
  localparam logic [2:0] RUN_SAT   = 3'd7;
  localparam logic [2:0] HELD_MAX  = 3'd3;
  localparam logic [2:0] LEN_MIN   = 3'd4;

  logic [2:0]  ones_q;
  logic        in_frame_q;
  logic [7:0]  acc_q;
  logic [2:0]  bcnt_q;
  logic [2:0]  nbytes_q;
  logic [15:0] crc_q;
  logic [7:0]  h0_q, h1_q, h2_q;

  // Named events for the checks below.
  logic       flag_evt, abort_evt, stuff_evt, data_evt, byte_done, close_ok;
  logic [7:0] new_byte, oldest_byte;

  assign flag_evt  = bit_en && !rx_bit && (ones_q == RUN_FLAG);
  assign abort_evt = bit_en &&  rx_bit && (ones_q == RUN_FLAG);
  assign stuff_evt = bit_en && !rx_bit && (ones_q == RUN_STUFF);
  assign data_evt  = bit_en && in_frame_q && !flag_evt && !abort_evt && !stuff_evt;
  assign new_byte  = {rx_bit, acc_q[7:1]};
  assign byte_done = data_evt && (bcnt_q == 3'd7);
  assign close_ok  = (bcnt_q == 3'd7) && (crc_q == CRC_GOOD_RESIDUE);
  assign oldest_byte = (nbytes_q >= HELD_MAX) ? h2_q :
                       (nbytes_q == 3'd2)     ? h1_q : h0_q;
  assign frame_open = flag_evt;

  always_comb begin
    push            = 1'b0;
    push_entry.tag  = TAG_DATA;
    push_entry.data = h2_q;
    if (byte_done && (nbytes_q >= HELD_MAX)) begin
      push = 1'b1;
    end else if (flag_evt && in_frame_q && (nbytes_q == LEN_MIN)) begin
      push           = 1'b1;
      push_entry.tag = close_ok ? TAG_GOOD : TAG_BAD;
    end else if (abort_evt && in_frame_q && (nbytes_q != 3'd0)) begin
      push            = 1'b1;
      push_entry.tag  = TAG_ABORT;
      push_entry.data = oldest_byte;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ones_q     <= '0;
      in_frame_q <= 1'b0;
      acc_q      <= '0;
      bcnt_q     <= '0;
      nbytes_q   <= '0;
      crc_q      <= CRC_SEED;
      h0_q       <= '0;
      h1_q       <= '0;
      h2_q       <= '0;
    end else begin
      if (bit_en) begin
        if (!rx_bit)               ones_q <= '0;
        else if (ones_q != RUN_SAT) ones_q <= ones_q + 3'd1;
      end
      if (flag_evt) begin
        in_frame_q <= 1'b1;
        acc_q      <= '0;
        bcnt_q     <= '0;
        nbytes_q   <= '0;
        crc_q      <= CRC_SEED;
      end else if (abort_evt) begin
        in_frame_q <= 1'b0;
      end else if (data_evt) begin
        acc_q  <= new_byte;
        bcnt_q <= bcnt_q + 3'd1;
        if (byte_done) begin
          crc_q <= crc16_octet(crc_q, new_byte);
          h0_q  <= new_byte;
          h1_q  <= h0_q;
          h2_q  <= h1_q;
          if (nbytes_q != LEN_MIN) nbytes_q <= nbytes_q + 3'd1;
        end
      end
    end
  end

  AST_PUSH_NEEDS_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> bit_en);  // R1
  AST_STUFF_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (stuff_evt && in_frame_q) |=> $stable(bcnt_q));  // R3
  AST_GOOD_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
    (push && push_entry.tag == TAG_GOOD) |=> (in_frame_q && nbytes_q == 3'd0));  // R4
  AST_ABORT_HUNTS: assert property (@(posedge clk) disable iff (!rst_n)
    (push && push_entry.tag == TAG_ABORT) |=> !in_frame_q);  // R7

endmodule

// File: rtl/hdlc_rx_fifo.sv
module hdlc_rx_fifo
  import hdlc_rx_pkg::*;
#(
  parameter int  DEPTH = 128,
  localparam int AW    = $clog2(DEPTH),
  localparam int CW    = AW + 1
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      wr,
  input  rx_entry_t wdata,
  input  logic      rd,
  output rx_entry_t rdata,
  output logic      empty,
  output logic      full
);

  rx_entry_t      mem [DEPTH];
  logic [AW-1:0]  wp_q, rp_q;
  logic [CW-1:0]  cnt_q;
  logic           wr_fire, rd_fire;

  assign empty   = (cnt_q == '0);
  assign full    = (cnt_q == CW'(DEPTH));
  assign wr_fire = wr && !full;
  assign rd_fire = rd && !empty;
  assign rdata   = mem[rp_q];

  function automatic logic [AW-1:0] ptr_next(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (wr_fire) mem[wp_q] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (wr_fire) wp_q <= ptr_next(wp_q);
      if (rd_fire) rp_q <= ptr_next(rp_q);
      case ({wr_fire, rd_fire})
        2'b10:   cnt_q <= cnt_q + CW'(1);
        2'b01:   cnt_q <= cnt_q - CW'(1);
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(DEPTH));  // R8
  AST_FILL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && !full && !(rd && !empty)) |=> (cnt_q == $past(cnt_q) + CW'(1)));  // R8
  AST_DRAIN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && !empty && !(wr && !full)) |=> (cnt_q == $past(cnt_q) - CW'(1)));  // R8

endmodule

// File: rtl/hdlc_frame_rx.sv
module hdlc_frame_rx
  import hdlc_rx_pkg::*;
#(
  parameter int  SLOTS      = 32,
  parameter int  LANES      = 8,
  parameter int  FIFO_DEPTH = 128,
  localparam int SW         = $clog2(SLOTS),
  localparam int BW         = $clog2(LANES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_valid,
  input  logic [SW-1:0]    slot_idx,
  input  logic [BW-1:0]    bit_idx,
  input  logic             rx_bit,
  input  logic [SLOTS-1:0] slot_mask,
  input  logic [LANES-1:0] bit_mask,
  input  logic             rd_en,
  output logic [7:0]       rd_data,
  output logic [1:0]       rd_tag,
  output logic             rx_empty,
  output logic             rx_overrun
);

  logic      bit_en;
  logic      df_push, frame_open;
  rx_entry_t df_entry, fifo_rdata;
  logic      fifo_full, fifo_wr, overflow_evt;
  logic      drop_q, overrun_q;

  hdlc_rx_map #(.SLOTS(SLOTS), .LANES(LANES)) map_i (
    .bit_valid (bit_valid),
    .slot_idx  (slot_idx),
    .bit_idx   (bit_idx),
    .slot_mask (slot_mask),
    .bit_mask  (bit_mask),
    .bit_en    (bit_en)
  );

  hdlc_rx_deframe deframe_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .bit_en     (bit_en),
    .rx_bit     (rx_bit),
    .push       (df_push),
    .push_entry (df_entry),
    .frame_open (frame_open)
  );

  assign overflow_evt = df_push && !drop_q && fifo_full;
  assign fifo_wr      = df_push && !drop_q && !fifo_full;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      drop_q    <= 1'b0;
      overrun_q <= 1'b0;
    end else begin
      if (frame_open)        drop_q <= 1'b0;
      else if (overflow_evt) drop_q <= 1'b1;
      if (overflow_evt) overrun_q <= 1'b1;
    end
  end

  hdlc_rx_fifo #(.DEPTH(FIFO_DEPTH)) fifo_i (
    .clk   (clk),
    .rst_n (rst_n),
    .wr    (fifo_wr),
    .wdata (df_entry),
    .rd    (rd_en),
    .rdata (fifo_rdata),
    .empty (rx_empty),
    .full  (fifo_full)
  );

  assign rd_data    = fifo_rdata.data;
  assign rd_tag     = fifo_rdata.tag;
  assign rx_overrun = overrun_q;

  AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    rx_overrun |=> rx_overrun);  // R9
  AST_OVR_ON_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (df_push && fifo_full) |=> rx_overrun);  // R9
  AST_DROP_BLOCKS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (drop_q && df_push && !rd_en) |=> $stable(rx_empty));  // R9

endmodule

// File: tb/hdlc_frame_rx_tb_top.sv
`timescale 1ns/1ps
module hdlc_frame_rx_tb_top;

  localparam logic [1:0]  T_DATA = 2'd0, T_GOOD = 2'd1, T_BAD = 2'd2, T_ABORT = 2'd3;
  localparam logic [31:0] SLOT_SEL = 32'h8000_4021;
  localparam logic [7:0]  LANE_SEL = 8'b1010_0101;
  localparam logic [7:0]  FLAG_PAT = 8'h7E;

  // Vector: length, seed, flags (bit0 corrupt FCS, bit1 constant bytes)
  localparam int NV = 6;
  localparam logic [23:0] VEC [NV] = '{
    {8'd2,  8'h41, 8'h00},
    {8'd5,  8'hFF, 8'h02},
    {8'd6,  8'h10, 8'h01},
    {8'd9,  8'h7E, 8'h02},
    {8'd12, 8'h3C, 8'h00},
    {8'd3,  8'hF8, 8'h00}
  };

  logic       clk, rst_n, bit_valid, rx_bit, rd_en;
  logic [4:0] slot_idx;
  logic [2:0] bit_idx;
  logic [7:0] rd_data;
  logic [1:0] rd_tag;
  logic       rx_empty, rx_overrun;

  int errors = 0, checks = 0;
  int pos_s = 0, pos_b = 0, gap_ctr = 0, ones_run = 0;
  logic [7:0] fbuf [0:159];

  hdlc_frame_rx dut_i (
    .clk(clk), .rst_n(rst_n), .bit_valid(bit_valid), .slot_idx(slot_idx),
    .bit_idx(bit_idx), .rx_bit(rx_bit), .slot_mask(SLOT_SEL), .bit_mask(LANE_SEL),
    .rd_en(rd_en), .rd_data(rd_data), .rd_tag(rd_tag), .rx_empty(rx_empty),
    .rx_overrun(rx_overrun)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Present one payload bit at the next selected position; junk elsewhere.
  task automatic tx_bit(input logic b);
    bit taken = 0;
    while (!taken) begin
      @(negedge clk);
      if (gap_ctr == 6) begin
        gap_ctr   = 0;
        bit_valid = 1'b0;
        slot_idx  = 5'd0;
        bit_idx   = 3'd0;
        rx_bit    = 1'($urandom);
      end else begin
        gap_ctr++;
        bit_valid = 1'b1;
        slot_idx  = 5'(pos_s);
        bit_idx   = 3'(pos_b);
        if (SLOT_SEL[pos_s] && LANE_SEL[pos_b]) begin
          rx_bit = b;
          taken  = 1;
        end else begin
          rx_bit = 1'($urandom);
        end
        if (pos_b == 7) begin
          pos_b = 0;
          pos_s = (pos_s + 1) % 32;
        end else begin
          pos_b++;
        end
      end
    end
  endtask

  task automatic tx_flag();
    for (int i = 0; i < 8; i++) tx_bit(FLAG_PAT[i]);
    ones_run = 0;
  endtask

  task automatic tx_byte(input logic [7:0] v);
    for (int i = 0; i < 8; i++) begin
      tx_bit(v[i]);
      if (v[i]) ones_run++; else ones_run = 0;
      if (ones_run == 5) begin
        tx_bit(1'b0);
        ones_run = 0;
      end
    end
  endtask

  task automatic go_idle();
    @(negedge clk);
    bit_valid = 1'b0;
    rx_bit    = 1'b0;
  endtask

  function automatic logic [15:0] serial_crc(input int len);
    logic [15:0] r = 16'hFFFF;
    for (int k = 0; k < len; k++)
      for (int j = 0; j < 8; j++) begin
        logic fb = r[0] ^ fbuf[k][j];
        r = {1'b0, r[15:1]};
        if (fb) r = r ^ 16'h8408;
      end
    return r;
  endfunction

  task automatic send_frame(input int len, input bit corrupt);
    logic [15:0] fcs = ~serial_crc(len);
    if (corrupt) fcs = fcs ^ 16'h0100;
    tx_flag();
    tx_flag();
    for (int i = 0; i < len; i++) tx_byte(fbuf[i]);
    tx_byte(fcs[7:0]);
    tx_byte(fcs[15:8]);
    tx_flag();
    tx_flag();
    go_idle();
  endtask

  task automatic fill(input int len, input logic [7:0] seed, input bit constant);
    for (int i = 0; i < len; i++) fbuf[i] = constant ? seed : seed + 8'(i * 29);
  endtask

  task automatic pop(output logic [7:0] d, output logic [1:0] t, output logic e);
    @(negedge clk);
    e = rx_empty; d = rd_data; t = rd_tag;
    rd_en = !e;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic expect_entry(input logic [7:0] d_exp, input logic [1:0] t_exp, input string req);
    logic [7:0] d; logic [1:0] t; logic e;
    pop(d, t, e);
    chk(!e && d == d_exp && t == t_exp, req, {e, t, d}, {1'b0, t_exp, d_exp});
  endtask

  task automatic expect_empty(input string req);
    @(negedge clk);
    chk(rx_empty == 1'b1, req, rx_empty, 1);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; bit_valid = 1'b0; rx_bit = 1'b0; rd_en = 1'b0;
    slot_idx = '0; bit_idx = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(rx_empty == 1'b1, "R10 empty after reset", rx_empty, 1);
    chk(rx_overrun == 1'b0, "R10 overrun clear after reset", rx_overrun, 0);

    // R10: bits before any flag store nothing
    for (int i = 0; i < 40; i++) tx_bit(1'(i % 2));
    go_idle();
    expect_empty("R10 no entry before first flag");

    // Table of frames
    for (int v = 0; v < NV; v++) begin
      int len = int'(VEC[v][23:16]);
      bit bad = VEC[v][0];
      fill(len, VEC[v][15:8], VEC[v][1]);
      send_frame(len, bad);
      for (int i = 0; i < len; i++)
        expect_entry(fbuf[i], (i == len - 1) ? (bad ? T_BAD : T_GOOD) : T_DATA,
                     bad ? $sformatf("R5 vec%0d byte%0d", v, i)
                         : $sformatf("R2 R3 R4 R1 vec%0d byte%0d", v, i));
      expect_empty($sformatf("R4 check bytes not stored vec%0d", v));
    end

    // R6: one payload byte plus two check bytes is too short
    fbuf[0] = 8'hA5;
    send_frame(1, 1'b0);
    expect_empty("R6 short frame discarded");

    // R7: abort after six bytes
    tx_flag(); tx_flag();
    tx_byte(8'h11); tx_byte(8'h22); tx_byte(8'h33);
    tx_byte(8'h44); tx_byte(8'h55); tx_byte(8'h66);
    for (int i = 0; i < 8; i++) tx_bit(1'b1);
    for (int i = 0; i < 4; i++) tx_bit(1'b0);
    go_idle();
    expect_entry(8'h11, T_DATA, "R7 abort byte0");
    expect_entry(8'h22, T_DATA, "R7 abort byte1");
    expect_entry(8'h33, T_DATA, "R7 abort byte2");
    expect_entry(8'h44, T_ABORT, "R7 abort tag");
    expect_empty("R7 nothing after abort");
    fill(2, 8'h5A, 1'b0);
    send_frame(2, 1'b0);
    expect_entry(fbuf[0], T_DATA, "R7 recovery byte0");
    expect_entry(fbuf[1], T_GOOD, "R7 recovery end");

    // R5: frame closed on a partial byte
    tx_flag(); tx_flag();
    tx_byte(8'h12); tx_byte(8'h34); tx_byte(8'h56); tx_byte(8'h07);
    tx_bit(1'b0); tx_bit(1'b0); tx_bit(1'b1);
    tx_flag(); tx_flag();
    go_idle();
    expect_entry(8'h12, T_DATA, "R5 misaligned byte0");
    expect_entry(8'h34, T_DATA, "R5 misaligned byte1");
    expect_entry(8'h56, T_BAD, "R5 misaligned end");
    expect_empty("R5 misaligned nothing more");

    // R9 / R8: overrun with a 140-byte message
    fill(140, 8'h05, 1'b0);
    send_frame(140, 1'b0);
    @(negedge clk);
    chk(rx_overrun == 1'b1, "R9 overrun set", rx_overrun, 1);
    begin
      int mism = 0;
      for (int i = 0; i < 128; i++) begin
        logic [7:0] d; logic [1:0] t; logic e;
        pop(d, t, e);
        if (e || d != fbuf[i] || t != T_DATA) mism++;
      end
      chk(mism == 0, "R8 R9 128 stored entries", mism, 0);
    end
    expect_empty("R8 R9 depth 128 and end tag dropped");
    fill(2, 8'hC3, 1'b0);
    send_frame(2, 1'b0);
    expect_entry(fbuf[0], T_DATA, "R9 next message byte0");
    expect_entry(fbuf[1], T_GOOD, "R9 next message end");
    @(negedge clk);
    chk(rx_overrun == 1'b1, "R9 overrun sticky", rx_overrun, 1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule